// File: doc/BRIEF.md
# Host Command Mailbox

This block is the register face of a command channel between a host processor and an embedded power-management controller. The host sees a small 32-bit register window. It may load a source pointer, a destination pointer and up to four payload words. It then writes a command word. That write marks the mailbox busy and sends a single-cycle doorbell pulse to the controller. With the pulse, the controller receives the command word, both pointers and the payload.

When the controller has finished, it pulses a completion strobe. With that strobe it supplies an error flag, an 8-bit error code and four response words. The mailbox clears busy and stores the result where the host can read it. Each command chooses how the host learns of completion. If bit 8 of the command word is set, completion raises a sticky interrupt flag. That flag drives a level interrupt until the host writes a one to clear it. If bit 8 is clear, the host polls the busy bit instead.

Top module: `host_mailbox`

## Requirements
- R1: Registers sit at these byte offsets: command word 0x00, status 0x04, source pointer 0x08, destination pointer 0x0C, payload words 0x80/0x84/0x88/0x8C and response words 0x90/0x94/0x98/0x9C. Pointer and payload registers read back what was written and appear unchanged on the controller outputs. Payload word i sits at bits 32i+31:32i of the payload output.
- R2: A command write accepted while idle sets busy and raises the doorbell for exactly the cycle after the write edge. The full command word appears on the command output.
- R3: The status word has busy in bit 0, the error flag in bit 1, interrupt-pending in bit 2 and the error code in bits 23:16. All other bits read as zero.
- R4: A completion strobe while busy clears busy in the next cycle. It loads the error flag and the error code, and the code reads as zero when the error flag is clear. It also loads the four response words, with word i taken from bits 32i+31:32i. The error flag and code then hold until the next completion.
- R5: A completion for a command whose bit 8 was set raises interrupt-pending and the interrupt output, and both stay high until cleared. A completion for a command with bit 8 clear leaves them low.
- R6: A status write with bit 2 set clears interrupt-pending. Other bits of a status write have no effect. A completion that sets the flag in the same cycle as a clear wins.
- R7: A command write while busy is dropped. It fires no doorbell and leaves the stored command word unchanged.
- R8: A completion strobe while idle changes neither the status word nor the response words.
- R9: Reads of unmapped offsets return zero. Host writes to the response words have no effect.
- R10: After reset the status, command, pointer and buffer registers read zero, and the doorbell and interrupt outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hwr_en | input | 1 | Host write strobe |
| haddr | input | AW | Host byte address |
| hwdata | input | 32 | Host write data |
| hrdata | output | 32 | Host read data for haddr (combinational) |
| ctl_doorbell | output | 1 | One-cycle pulse on an accepted command |
| ctl_cmd | output | 32 | Last accepted command word |
| ctl_src | output | 32 | Source pointer |
| ctl_dst | output | 32 | Destination pointer |
| ctl_payload | output | 32*NW | Payload words, word i at bits 32i+31:32i |
| ctl_done | input | 1 | Completion strobe from the controller |
| ctl_err | input | 1 | Error flag sampled with ctl_done |
| ctl_code | input | 8 | Error code sampled with ctl_done |
| ctl_resp | input | 32*NW | Response words sampled with ctl_done |
| host_irq | output | 1 | Level interrupt while the pending flag is set |

## Verification
Commands are tried in three forms: with bit 8 clear, with bit 8 set and a successful completion, and with bit 8 set and an error completion. These show whether the interrupt path follows the per-command bit and whether the error fields follow the completion. A second command write while busy, and a completion strobe while idle, show whether the block gates each event on busy. Status writes are tried with bit 2 clear and with bit 2 set, and a clear is made to coincide with a completion. These cases separate a sticky flag from a write-through register and fix the priority between set and clear. Response-word writes and unmapped reads confirm that the read path exposes only mapped state.

// File: rtl/host_mailbox.sv
module host_mailbox #(
  parameter int AW = 8,
  parameter int NW = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hwr_en,
  input  logic [AW-1:0]    haddr,
  input  logic [31:0]      hwdata,
  output logic [31:0]      hrdata,
  output logic             ctl_doorbell,
  output logic [31:0]      ctl_cmd,
  output logic [31:0]      ctl_src,
  output logic [31:0]      ctl_dst,
  output logic [32*NW-1:0] ctl_payload,
  input  logic             ctl_done,
  input  logic             ctl_err,
  input  logic [7:0]       ctl_code,
  input  logic [32*NW-1:0] ctl_resp,
  output logic             host_irq
);
  localparam logic [AW-1:0] OFF_CMD = AW'(8'h00);
  localparam logic [AW-1:0] OFF_STS = AW'(8'h04);
  localparam logic [AW-1:0] OFF_SRC = AW'(8'h08);
  localparam logic [AW-1:0] OFF_DST = AW'(8'h0C);
  localparam logic [AW-1:0] OFF_WB  = AW'(8'h80);
  localparam logic [AW-1:0] OFF_RB  = AW'(8'h90);
  localparam int IRQ_BIT = 8;

  logic        busy, err, ipend;
  logic [7:0]  code;
  logic [31:0] cmd_q, src_q, dst_q;
  logic [31:0] wbuf [NW];
  logic [31:0] rbuf [NW];
  logic [31:0] status;

  wire cmd_wr = hwr_en && haddr == OFF_CMD;
  wire sts_wr = hwr_en && haddr == OFF_STS;
  wire finish = ctl_done && busy;

  assign status       = {8'h00, code, 13'h0000, ipend, err, busy};
  assign ctl_cmd      = cmd_q;
  assign ctl_src      = src_q;
  assign ctl_dst      = dst_q;
  assign host_irq     = ipend;

  for (genvar g = 0; g < NW; g++) begin : g_pack
    assign ctl_payload[32*g +: 32] = wbuf[g];
  end

  always_comb begin
    hrdata = '0;
    case (haddr)
      OFF_CMD: hrdata = cmd_q;
      OFF_STS: hrdata = status;
      OFF_SRC: hrdata = src_q;
      OFF_DST: hrdata = dst_q;
      default: ;
    endcase
    for (int i = 0; i < NW; i++) begin
      if (haddr == OFF_WB + AW'(4*i)) hrdata = wbuf[i];
      if (haddr == OFF_RB + AW'(4*i)) hrdata = rbuf[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy         <= 1'b0;
      err          <= 1'b0;
      ipend        <= 1'b0;
      code         <= '0;
      cmd_q        <= '0;
      src_q        <= '0;
      dst_q        <= '0;
      ctl_doorbell <= 1'b0;
      for (int i = 0; i < NW; i++) begin
        wbuf[i] <= '0;
        rbuf[i] <= '0;
      end
    end else begin
      ctl_doorbell <= 1'b0;
      if (cmd_wr && !busy) begin
        cmd_q        <= hwdata;
        busy         <= 1'b1;
        ctl_doorbell <= 1'b1;
      end
      if (hwr_en && haddr == OFF_SRC) src_q <= hwdata;
      if (hwr_en && haddr == OFF_DST) dst_q <= hwdata;
      for (int i = 0; i < NW; i++)
        if (hwr_en && haddr == OFF_WB + AW'(4*i)) wbuf[i] <= hwdata;
      if (sts_wr && hwdata[2]) ipend <= 1'b0;
      if (finish) begin
        busy <= 1'b0;
        err  <= ctl_err;
        code <= ctl_err ? ctl_code : 8'h00;
        for (int i = 0; i < NW; i++) rbuf[i] <= ctl_resp[32*i +: 32];
        if (cmd_q[IRQ_BIT]) ipend <= 1'b1;
      end
    end
  end
endmodule

module host_mailbox_sva #(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          hwr_en,
  input logic [AW-1:0] haddr,
  input logic [31:0]   hwdata,
  input logic          busy,
  input logic          ipend,
  input logic          ctl_done,
  input logic          ctl_doorbell,
  input logic [31:0]   ctl_cmd,
  input logic          host_irq
);
  assert_doorbell_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_doorbell |-> $past(hwr_en && haddr == AW'(0) && !busy));
  assert_busy_rings_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ctl_doorbell);
  assert_done_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_done && busy) |=> !busy);
  assert_irq_raise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(host_irq) |-> $past(ctl_done && busy && ctl_cmd[8]));
  assert_irq_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(host_irq) |-> $past(hwr_en && haddr == AW'(4) && hwdata[2]));
  assert_drop_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (hwr_en && haddr == AW'(0) && busy) |=> (!ctl_doorbell && $stable(ctl_cmd)));
  assert_idle_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_done && !busy && !hwr_en) |=> (!busy && $stable(ipend)));
endmodule

bind host_mailbox host_mailbox_sva #(.AW(AW)) u_sva (.*);

// File: tb/host_mailbox_bench.sv
module host_mailbox_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam int NW = 4;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             hwr_en = 1'b0;
  logic [AW-1:0]    haddr = '0;
  logic [31:0]      hwdata = '0;
  logic [31:0]      hrdata;
  logic             ctl_doorbell;
  logic [31:0]      ctl_cmd, ctl_src, ctl_dst;
  logic [32*NW-1:0] ctl_payload;
  logic             ctl_done = 1'b0;
  logic             ctl_err = 1'b0;
  logic [7:0]       ctl_code = '0;
  logic [32*NW-1:0] ctl_resp = '0;
  logic             host_irq;
  logic             rd_strobe = 1'b0;

  int vectors = 0;
  int misses = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  host_mailbox #(.AW(AW), .NW(NW)) u_host_mailbox (
    .clk(clk), .rst_n(rst_n), .hwr_en(hwr_en), .haddr(haddr), .hwdata(hwdata),
    .hrdata(hrdata), .ctl_doorbell(ctl_doorbell), .ctl_cmd(ctl_cmd),
    .ctl_src(ctl_src), .ctl_dst(ctl_dst), .ctl_payload(ctl_payload),
    .ctl_done(ctl_done), .ctl_err(ctl_err), .ctl_code(ctl_code),
    .ctl_resp(ctl_resp), .host_irq(host_irq));

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s: got %08h expected %08h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rd_strobe) begin
      if (exp_q.size() == 0) check("monitor: read with empty queue", 32'h1, 32'h0);
      else check(tag_q.pop_front(), hrdata, exp_q.pop_front());
    end
  end

  task automatic wr(logic [AW-1:0] a, logic [31:0] d);
    @(posedge clk); #1;
    hwr_en = 1'b1; haddr = a; hwdata = d;
    @(posedge clk); #1;
    hwr_en = 1'b0;
  endtask

  task automatic rd(logic [AW-1:0] a, logic [31:0] exp, string tag);
    @(posedge clk); #1;
    haddr = a; rd_strobe = 1'b1;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(posedge clk); #1;
    rd_strobe = 1'b0;
  endtask

  task automatic complete(logic e, logic [7:0] c, logic [31:0] base);
    @(posedge clk); #1;
    ctl_done = 1'b1; ctl_err = e; ctl_code = c;
    for (int i = 0; i < NW; i++) ctl_resp[32*i +: 32] = base + 32'(i);
    @(posedge clk); #1;
    ctl_done = 1'b0;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    misses++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #(CLK_PERIOD/2) rst_n = 1'b1;

    check("R10 irq after reset", {31'b0, host_irq}, 32'h0);
    check("R10 doorbell after reset", {31'b0, ctl_doorbell}, 32'h0);
    rd(8'h04, 32'h0, "R10 status after reset");
    rd(8'h00, 32'h0, "R10 command after reset");
    rd(8'h90, 32'h0, "R10 response after reset");

    wr(8'h08, 32'h1000_0040);
    wr(8'h0C, 32'h2000_0080);
    for (int i = 0; i < NW; i++) wr(8'h80 + 8'(4*i), 32'hA0A0_0000 + 32'(i));
    rd(8'h08, 32'h1000_0040, "R1 source readback");
    rd(8'h0C, 32'h2000_0080, "R1 destination readback");
    rd(8'h84, 32'hA0A0_0001, "R1 payload word 1 readback");
    check("R1 source output", ctl_src, 32'h1000_0040);
    check("R1 destination output", ctl_dst, 32'h2000_0080);
    check("R1 payload word 1 output", ctl_payload[63:32], 32'hA0A0_0001);
    check("R1 payload word 3 output", ctl_payload[127:96], 32'hA0A0_0003);

    wr(8'h00, 32'h0010_3045);
    check("R2 doorbell after command", {31'b0, ctl_doorbell}, 32'h1);
    check("R2 command output", ctl_cmd, 32'h0010_3045);
    @(posedge clk); #1;
    check("R2 doorbell one cycle", {31'b0, ctl_doorbell}, 32'h0);
    rd(8'h04, 32'h0000_0001, "R3 busy status");
    rd(8'h00, 32'h0010_3045, "R1 command readback");

    wr(8'h00, 32'h0000_0111);
    check("R7 no doorbell while busy", {31'b0, ctl_doorbell}, 32'h0);
    check("R7 command kept", ctl_cmd, 32'h0010_3045);
    rd(8'h00, 32'h0010_3045, "R7 command readback kept");

    complete(1'b0, 8'h55, 32'hB000_0000);
    rd(8'h04, 32'h0, "R4 status after ok completion");
    check("R5 no irq when bit 8 clear", {31'b0, host_irq}, 32'h0);
    rd(8'h90, 32'hB000_0000, "R4 response word 0");
    rd(8'h9C, 32'hB000_0003, "R4 response word 3");

    wr(8'h90, 32'hFFFF_FFFF);
    rd(8'h90, 32'hB000_0000, "R9 response not host writable");
    rd(8'h40, 32'h0, "R9 unmapped 0x40");
    rd(8'hA0, 32'h0, "R9 unmapped 0xA0");

    wr(8'h00, 32'h0004_1146);
    complete(1'b1, 8'h07, 32'hC000_0000);
    rd(8'h04, 32'h0007_0006, "R3 error status with code");
    check("R5 irq raised", {31'b0, host_irq}, 32'h1);

    wr(8'h04, 32'hFFFF_FFFB);
    rd(8'h04, 32'h0007_0006, "R6 bit 2 clear write ignored");
    check("R6 irq held", {31'b0, host_irq}, 32'h1);

    complete(1'b0, 8'h00, 32'hD000_0000);
    rd(8'h04, 32'h0007_0006, "R8 idle completion status");
    rd(8'h90, 32'hC000_0000, "R8 idle completion response");

    wr(8'h04, 32'h0000_0004);
    rd(8'h04, 32'h0007_0002, "R6 pending cleared");
    check("R6 irq low", {31'b0, host_irq}, 32'h0);

    wr(8'h00, 32'h0000_2047);
    rd(8'h04, 32'h0007_0003, "R4 error held while busy");
    complete(1'b0, 8'h00, 32'hE000_0000);
    rd(8'h04, 32'h0, "R4 error cleared by completion");
    check("R5 no irq second polled", {31'b0, host_irq}, 32'h0);

    wr(8'h00, 32'h0000_0100);
    @(posedge clk); #1;
    ctl_done = 1'b1; ctl_err = 1'b0; ctl_code = 8'h00;
    hwr_en = 1'b1; haddr = 8'h04; hwdata = 32'h4;
    @(posedge clk); #1;
    ctl_done = 1'b0; hwr_en = 1'b0;
    rd(8'h04, 32'h0000_0004, "R6 set wins over clear");
    check("R6 irq after coincident", {31'b0, host_irq}, 32'h1);

    @(posedge clk); #1;
    finish_run();
  end
endmodule